// File: doc/BRIEF.md
# Double-Buffered Parallel DAC Latch Controller

This block is the parallel-load front end of a 14-bit digital-to-analog converter. A host drives a 14-bit data word together with three active-low strobes: a select, a write and a load strobe. The word first goes into an input register and is later moved into a DAC register. Only the DAC register drives the code output that feeds the converter core. Each change of the output code is marked with a one-clock update pulse.

Both registers behave as level-transparent latches. The input register is open while select and write are both low. The DAC register is open while the load strobe is low, but never while the input register is open. This interlock keeps a half-written word from reaching the output. With the load strobe tied low, a single write cycle therefore both captures a word and, once the write ends, presents it at the output. The strobes are asynchronous to the block. Each passes through a two-flop synchronizer, and the data bus is delayed by the same number of stages so that it stays aligned with the strobes. Transparency is modelled as a register load on every system clock during which the enable condition holds. Output codes are two's complement.

Top module: `pdac_latch_ctrl`

## Requirements
- R1: After synchronous reset, `code_out` is 0x0000 (midscale) and `update_pulse` is low.
- R2: While `sel_n` and `wr_n` are both low, the input register follows `data_in`, so the word present when the write ends is the one held.
- R3: When the write ends, the input register keeps the word captured at that moment, and later changes of `data_in` do not alter it.
- R4: A low level on `ld_n` copies the input register into the DAC register, and `code_out` then shows that word.
- R5: While the input register is open, `code_out` does not change, even with `ld_n` low.
- R6: With `ld_n` held low, one write cycle updates `code_out` to the written word once `sel_n` or `wr_n` returns high.
- R7: With `ld_n` high and at least one of `sel_n` or `wr_n` high, neither register changes, whatever `data_in` does.
- R8: `update_pulse` is high for exactly one clock in the same cycle that `code_out` takes a new value, and stays low when a transfer leaves the code unchanged.
- R9: Two's complement end codes pass through unchanged: 0x1FFF (most positive), 0x2000 (most negative) and 0x0000 (zero).
- R10: Whichever of `sel_n` or `wr_n` rises first ends the write: data changed after `sel_n` rises, with `wr_n` still low, is not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | 14 | Parallel data word, asynchronous |
| sel_n | input | 1 | Active-low chip select, asynchronous |
| wr_n | input | 1 | Active-low write strobe, asynchronous |
| ld_n | input | 1 | Active-low load strobe for the DAC register, asynchronous |
| code_out | output | 14 | Two's complement code held in the DAC register |
| update_pulse | output | 1 | One-clock pulse when code_out changes |

## Verification
Words are written with the load strobe held high and then transferred with a separate load pulse. Comparing this with writes made while the load strobe is held low separates the double-buffered path from the single-write update path. Changing the data bus during a write, after write rises and after select rises alone shows which edge closes the input register. Loading the same word twice, and driving a busy bus with every strobe inactive, checks that the update pulse follows real code changes only and that idle traffic leaves both registers unchanged.

// File: rtl/pdac_pkg.sv
package pdac_pkg;

    // Default resolution and synchronizer depth
    localparam int DEF_CODE_W  = 14;
    localparam int DEF_SYNC_N  = 2;

    // Synchronized strobe bundle, all active low
    typedef struct packed {
        logic sel_n;
        logic wr_n;
        logic ld_n;
    } strobe_t;

    localparam int STROBE_W = $bits(strobe_t);

    // Input register is open while both select and write are asserted
    function automatic logic input_window(strobe_t s);
        return (!s.sel_n) && (!s.wr_n);
    endfunction

    // DAC register is open on load, but never together with the input register
    function automatic logic dac_window(strobe_t s);
        return (!s.ld_n) && !input_window(s);
    endfunction

endpackage

// File: rtl/pdac_stage_chain.sv
module pdac_stage_chain #(
    parameter int W      = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= RST_VAL;
                    else     stage_q[g] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= RST_VAL;
                    else     stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pdac_gate.sv
module pdac_gate
    import pdac_pkg::*;
(
    input  strobe_t strobes,
    output logic    in_open,
    output logic    dac_open
);
    always_comb begin
        in_open  = input_window(strobes);
        dac_open = dac_window(strobes);
    end
endmodule

// File: rtl/pdac_hold_reg.sv
module pdac_hold_reg #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         open,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (open) q <= d;
    end
endmodule

// File: rtl/pdac_latch_ctrl.sv
module pdac_latch_ctrl
    import pdac_pkg::*;
#(
    parameter int CODE_W = DEF_CODE_W,
    parameter int SYNC_N = DEF_SYNC_N
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] data_in,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic              ld_n,
    output logic [CODE_W-1:0] code_out,
    output logic              update_pulse
);
    strobe_t           strobe_raw;
    strobe_t           strobe_sync;
    logic [CODE_W-1:0] data_aligned;
    logic [CODE_W-1:0] in_word;
    logic [CODE_W-1:0] dac_word;
    logic              in_open;
    logic              dac_open;
    logic              pulse_q;

    assign strobe_raw = '{sel_n: sel_n, wr_n: wr_n, ld_n: ld_n};

    // Strobes idle high out of reset
    pdac_stage_chain #(
        .W(STROBE_W), .STAGES(SYNC_N), .RST_VAL({STROBE_W{1'b1}})
    ) u_strobe_sync (
        .clk(clk), .rst(rst), .d(strobe_raw), .q(strobe_sync)
    );

    // Data delayed by the same depth so it lines up with the strobes
    pdac_stage_chain #(
        .W(CODE_W), .STAGES(SYNC_N), .RST_VAL('0)
    ) u_data_align (
        .clk(clk), .rst(rst), .d(data_in), .q(data_aligned)
    );

    pdac_gate u_gate (
        .strobes(strobe_sync), .in_open(in_open), .dac_open(dac_open)
    );

    pdac_hold_reg #(.W(CODE_W)) u_input_reg (
        .clk(clk), .rst(rst), .open(in_open), .d(data_aligned), .q(in_word)
    );

    pdac_hold_reg #(.W(CODE_W)) u_dac_reg (
        .clk(clk), .rst(rst), .open(dac_open), .d(in_word), .q(dac_word)
    );

    // Pulse lands in the same cycle the DAC register takes a new value
    always_ff @(posedge clk) begin
        if (rst) pulse_q <= 1'b0;
        else     pulse_q <= dac_open && (in_word != dac_word);
    end

    assign code_out     = dac_word;
    assign update_pulse = pulse_q;
endmodule

// File: rtl/pdac_latch_ctrl_chk.sv
module pdac_latch_ctrl_chk #(
    parameter int CODE_W = 14
) (
    input logic              clk,
    input logic              rst,
    input logic [CODE_W-1:0] code_out,
    input logic              update_pulse,
    input logic              in_open,
    input logic              dac_open,
    input logic [CODE_W-1:0] in_word
);
    AST_RESET_STATE: assert property (@(posedge clk)
        $past(rst) |-> (code_out == '0) && !update_pulse); // R1

    AST_NEVER_BOTH_OPEN: assert property (@(posedge clk) disable iff (rst)
        !(in_open && dac_open)); // R5

    AST_DAC_FROZEN_DURING_WRITE: assert property (@(posedge clk) disable iff (rst)
        in_open |=> $stable(code_out)); // R5

    AST_INPUT_HELD_WHEN_CLOSED: assert property (@(posedge clk) disable iff (rst)
        !in_open |=> $stable(in_word)); // R7

    AST_PULSE_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
        (code_out != $past(code_out)) |-> update_pulse); // R8

    AST_PULSE_ONLY_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
        update_pulse |-> (code_out != $past(code_out))); // R8

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        update_pulse |=> !update_pulse); // R8
endmodule

bind pdac_latch_ctrl pdac_latch_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
    .clk(clk), .rst(rst), .code_out(code_out), .update_pulse(update_pulse),
    .in_open(in_open), .dac_open(dac_open), .in_word(in_word)
);

// File: tb/pdac_latch_ctrl_tb_top.sv
module pdac_latch_ctrl_tb_top;
    localparam int W = 14;
    localparam int SETTLE = 6;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] data_in = '0;
    logic         sel_n = 1'b1;
    logic         wr_n  = 1'b1;
    logic         ld_n  = 1'b1;
    logic [W-1:0] code_out;
    logic         update_pulse;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pdac_latch_ctrl #(.CODE_W(W), .SYNC_N(2)) dut_i (
        .clk(clk), .rst(rst), .data_in(data_in), .sel_n(sel_n), .wr_n(wr_n),
        .ld_n(ld_n), .code_out(code_out), .update_pulse(update_pulse)
    );

    always @(negedge clk) if (!rst && update_pulse) pulses++;

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic sample_code(input string req, input logic [W-1:0] exp);
        @(negedge clk);
        check(req, code_out, exp);
        #1;
    endtask

    // Write with ld_n left as is; write ends on wr_n rising
    task automatic write_word(input logic [W-1:0] w);
        sel_n = 1'b0; wr_n = 1'b0; data_in = w;
        step(SETTLE);
        wr_n = 1'b1;
        step(SETTLE);
        sel_n = 1'b1;
        step(2);
    endtask

    task automatic load_pulse();
        ld_n = 1'b0;
        step(SETTLE);
        ld_n = 1'b1;
        step(SETTLE);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 code", code_out, 14'h0000);
        check("R1 pulse", update_pulse, 1'b0);
        #1;
    endtask

    task automatic t_double_buffer();
        pulses = 0;
        sel_n = 1'b0; wr_n = 1'b0; data_in = 14'h0123;
        step(SETTLE);
        data_in = 14'h0A5A;           // input follows the bus
        step(SETTLE);
        sample_code("R2 output held during write", 14'h0000);
        wr_n = 1'b1;
        step(SETTLE);
        data_in = 14'h3333;           // after write end
        step(SETTLE);
        sel_n = 1'b1;
        step(SETTLE);
        sample_code("R3 output before load", 14'h0000);
        load_pulse();
        sample_code("R2 R3 R4 loaded word", 14'h0A5A);
        check("R8 one pulse per load", pulses, 1);
    endtask

    task automatic t_select_first();
        sel_n = 1'b0; wr_n = 1'b0; data_in = 14'h0777;
        step(SETTLE);
        sel_n = 1'b1;                 // select ends the write
        step(SETTLE);
        data_in = 14'h1555;
        step(SETTLE);
        wr_n = 1'b1;
        step(SETTLE);
        load_pulse();
        sample_code("R10 select edge captures", 14'h0777);
    endtask

    task automatic t_interlock();
        pulses = 0;
        ld_n = 1'b0;
        step(SETTLE);
        sel_n = 1'b0; wr_n = 1'b0; data_in = 14'h1234;
        step(SETTLE);
        sample_code("R5 blocked while input open", 14'h0777);
        data_in = 14'h0246;
        step(SETTLE);
        sample_code("R5 still blocked", 14'h0777);
        wr_n = 1'b1;
        step(SETTLE);
        sample_code("R6 single write updates", 14'h0246);
        check("R8 pulse count single write", pulses, 1);
        sel_n = 1'b1;
        step(SETTLE);
        ld_n = 1'b1;
        step(SETTLE);
    endtask

    task automatic t_hold();
        pulses = 0;
        wr_n = 1'b0; sel_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            data_in = 14'(k * 14'h0911);
            step(3);
        end
        wr_n = 1'b1; sel_n = 1'b0;
        data_in = 14'h2AAA;
        step(SETTLE);
        sel_n = 1'b1;
        data_in = 14'h3FFF;
        step(SETTLE);
        sample_code("R7 output held when idle", 14'h0246);
        check("R7 no pulse when idle", pulses, 0);
        load_pulse();
        sample_code("R7 input register unchanged", 14'h0246);
        check("R8 no pulse on same code", pulses, 0);
    endtask

    task automatic t_codes();
        ld_n = 1'b0;
        step(SETTLE);
        write_word(14'h1FFF);
        step(SETTLE);
        sample_code("R9 most positive", 14'h1FFF);
        write_word(14'h2000);
        step(SETTLE);
        sample_code("R9 most negative", 14'h2000);
        write_word(14'h0000);
        step(SETTLE);
        sample_code("R9 zero", 14'h0000);
        ld_n = 1'b1;
        step(SETTLE);
    endtask

    task automatic t_pulse_width();
        int high_run = 0;
        int max_run  = 0;
        write_word(14'h0F0F);
        ld_n = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (update_pulse) high_run++; else high_run = 0;
            if (high_run > max_run) max_run = high_run;
        end
        #1;
        ld_n = 1'b1;
        step(SETTLE);
        check("R8 pulse lasts one clock", max_run, 1);
        sample_code("R4 transfer", 14'h0F0F);
    endtask

    initial begin
        step(4);
        rst = 1'b0;
        step(1);
        t_reset();
        t_double_buffer();
        t_select_first();
        t_interlock();
        t_hold();
        t_codes();
        t_pulse_width();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule